// File: doc/BRIEF.md
# Four-Beat Burst Split-Port SRAM

This block is a synthesizable model of a synchronous SRAM that has a dedicated write port and a dedicated read port. The two ports share one group address input. Every access moves a burst of four words. The block runs on one core clock. Each core cycle carries two data beats, presented on a pair of parallel buses: the `*_rise` bus holds the beat for the rising edge and the `*_fall` bus holds the beat for the falling edge. An access therefore spans two core cycles. Read data is launched from the same core clock, so the block models single-clock output mode.

The group address selects one four-word aligned group. The beat index inside the group comes from the burst sequencing. A write carries its data in the cycle it is accepted and in the cycle after. Each beat has its own byte-lane mask, and a lane is 9 bits wide. A read that overlaps a write to the same group returns the newest data. Between bursts the read bus is held at zero and flagged as not driven.

The interface has no back-pressure. A request that arrives while its port is still inside a burst is dropped, and the requester must space its requests two cycles apart on each port.

Top module: `qb_sram`

## Requirements
- R1: When `wps_n` is low at a rising edge and no write burst is in its second cycle, the write is accepted for group G = `addr`. `d_rise`/`d_fall` of that cycle are stored at word indices 4G+0 and 4G+1. `d_rise`/`d_fall` of the next cycle are stored at 4G+2 and 4G+3.
- R2: While `wps_n` is high and no write burst is in progress, `d_rise`, `d_fall`, the masks and `addr` change no stored word.
- R3: Mask bit i low writes bits 9i+8..9i of its beat. Mask bit i high leaves those bits unchanged. `bws_rise_n` qualifies `d_rise` and `bws_fall_n` qualifies `d_fall`, each in the same cycle as its data.
- R4: A read accepted at edge t (`rps_n` low) drives words 4G+0 and 4G+1 on `q_rise`/`q_fall` after edge t+1, and words 4G+2 and 4G+3 after edge t+2. `q_oe` is high for exactly those two cycles. Reads accepted two cycles apart give gap-free output.
- R5: A read request at the edge right after an accepted read is ignored. No burst follows it.
- R6: A write request at the edge right after an accepted write is ignored. That cycle only supplies the second half of the running burst, which goes to the first burst's group.
- R7: A read accepted at the same edge as a write to the same group, or at the edge after one, returns all four new words, including the lane masking of the second half.
- R8: A write accepted at the edge after a read of the same group does not change that read's data.
- R9: Whenever `q_oe` is low, `q_rise` and `q_fall` are zero.
- R10: After reset, `q_oe` is low and no read or write burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; every request is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | AW | Group address shared by both ports |
| wps_n | input | 1 | Write request, active low |
| bws_rise_n | input | LANES | Active-low lane mask for `d_rise` |
| bws_fall_n | input | LANES | Active-low lane mask for `d_fall` |
| d_rise | input | 9*LANES | Write beat for the rising edge |
| d_fall | input | 9*LANES | Write beat for the falling edge |
| rps_n | input | 1 | Read request, active low |
| q_rise | output | 9*LANES | Read beat for the rising edge |
| q_fall | output | 9*LANES | Read beat for the falling edge |
| q_oe | output | 1 | High while a read beat pair is valid; low means bus released |

## Verification
Two functions can meet in the same cycle. The first is the read fetch, which collects all four words of a group in one cycle. The second is the second half of a write burst to that same group. The bench provokes this overlap by issuing a read together with a write, and also by issuing a read in the write's second cycle. It gives the trailing beat a partial lane mask and compares all four returned words against a reference array. The reverse ordering also gets a case: a write accepted one cycle after the read, which must leave the returned data unchanged.

// File: rtl/qb_sram_pkg.sv
package qb_sram_pkg;
  localparam int LANE_BITS = 9;
  localparam int BURST_LEN = 4;
endpackage

// File: rtl/qb_sram_wr.sv
module qb_sram_wr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wps_n,
  input  logic [AW-1:0] addr,
  output logic          wr_acc,
  output logic          wr_act,
  output logic          wr_hi,
  output logic [AW-1:0] wr_grp
);
  logic          second_q;
  logic [AW-1:0] grp_q;

  // a request is taken only when no burst is in its second half
  assign wr_acc = !wps_n && !second_q;
  assign wr_act = wr_acc || second_q;
  assign wr_hi  = second_q;
  assign wr_grp = second_q ? grp_q : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      grp_q    <= '0;
    end else begin
      second_q <= wr_acc;
      if (wr_acc) grp_q <= addr;
    end
  end
endmodule

// File: rtl/qb_sram_array.sv
module qb_sram_array
  import qb_sram_pkg::*;
#(
  parameter int LANES = 2,
  parameter int AW    = 4
) (
  input  logic                       clk,
  input  logic                       wr_act,
  input  logic                       wr_hi,
  input  logic [AW-1:0]              wr_grp,
  input  logic [LANES*LANE_BITS-1:0] d_rise,
  input  logic [LANES*LANE_BITS-1:0] d_fall,
  input  logic [LANES-1:0]           en_rise,
  input  logic [LANES-1:0]           en_fall,
  input  logic [AW-1:0]              rd_grp,
  output logic [BURST_LEN*LANES*LANE_BITS-1:0] rd_words
);
  localparam int W     = LANES * LANE_BITS;
  localparam int DEPTH = BURST_LEN << AW;
  localparam int IW    = AW + 2;

  logic [W-1:0] mem [DEPTH];

  function automatic logic [W-1:0] lane_mix(input logic [W-1:0] old_w,
                                            input logic [W-1:0] new_w,
                                            input logic [LANES-1:0] en);
    logic [W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_BITS +: LANE_BITS] = new_w[i*LANE_BITS +: LANE_BITS];
    return r;
  endfunction

  logic [IW-1:0] idx_r, idx_f;
  logic [W-1:0]  new_r, new_f;

  assign idx_r = {wr_grp, wr_hi, 1'b0};
  assign idx_f = {wr_grp, wr_hi, 1'b1};
  assign new_r = lane_mix(mem[idx_r], d_rise, en_rise);
  assign new_f = lane_mix(mem[idx_f], d_fall, en_fall);

  always_ff @(posedge clk) begin
    if (wr_act) begin
      mem[idx_r] <= new_r;
      mem[idx_f] <= new_f;
    end
  end

  // all four words are fetched at once; the trailing pair may still be in flight
  logic fwd_hit;
  assign fwd_hit = wr_act && wr_hi && (wr_grp == rd_grp);

  for (genvar k = 0; k < BURST_LEN; k++) begin : g_beat
    localparam logic [1:0] KB = 2'(k);
    logic [W-1:0] stored;
    assign stored = mem[{rd_grp, KB}];
    if (k >= 2) begin : g_fwd
      assign rd_words[k*W +: W] = !fwd_hit ? stored :
        (KB[0] ? lane_mix(stored, d_fall, en_fall) : lane_mix(stored, d_rise, en_rise));
    end else begin : g_plain
      assign rd_words[k*W +: W] = stored;
    end
  end
endmodule

// File: rtl/qb_sram_rd.sv
module qb_sram_rd
  import qb_sram_pkg::*;
#(
  parameter int LANES = 2,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rps_n,
  input  logic [AW-1:0] addr,
  input  logic [BURST_LEN*LANES*LANE_BITS-1:0] rd_words,
  output logic          rd_acc,
  output logic [AW-1:0] rd_grp,
  output logic [LANES*LANE_BITS-1:0] q_rise,
  output logic [LANES*LANE_BITS-1:0] q_fall,
  output logic          q_oe
);
  localparam int W = LANES * LANE_BITS;

  logic         pend_q, tail_q;
  logic [W-1:0] hold_r, hold_f;

  assign rd_acc = !rps_n && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tail_q <= 1'b0;
      rd_grp <= '0;
      hold_r <= '0;
      hold_f <= '0;
      q_rise <= '0;
      q_fall <= '0;
      q_oe   <= 1'b0;
    end else begin
      pend_q <= rd_acc;
      tail_q <= pend_q;
      if (rd_acc) rd_grp <= addr;
      if (pend_q) begin
        q_rise <= rd_words[0*W +: W];
        q_fall <= rd_words[1*W +: W];
        hold_r <= rd_words[2*W +: W];
        hold_f <= rd_words[3*W +: W];
        q_oe   <= 1'b1;
      end else if (tail_q) begin
        q_rise <= hold_r;
        q_fall <= hold_f;
        q_oe   <= 1'b1;
      end else begin
        q_rise <= '0;
        q_fall <= '0;
        q_oe   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qb_sram.sv
module qb_sram
  import qb_sram_pkg::*;
#(
  parameter int LANES = 2,
  parameter int AW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              addr,
  input  logic                       wps_n,
  input  logic [LANES-1:0]           bws_rise_n,
  input  logic [LANES-1:0]           bws_fall_n,
  input  logic [LANES*LANE_BITS-1:0] d_rise,
  input  logic [LANES*LANE_BITS-1:0] d_fall,
  input  logic                       rps_n,
  output logic [LANES*LANE_BITS-1:0] q_rise,
  output logic [LANES*LANE_BITS-1:0] q_fall,
  output logic                       q_oe
);
  localparam int W = LANES * LANE_BITS;

  logic          wr_acc, wr_act, wr_hi, rd_acc;
  logic [AW-1:0] wr_grp, rd_grp;
  logic [BURST_LEN*W-1:0] rd_words;

  qb_sram_wr #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wps_n(wps_n), .addr(addr),
    .wr_acc(wr_acc), .wr_act(wr_act), .wr_hi(wr_hi), .wr_grp(wr_grp)
  );

  qb_sram_array #(.LANES(LANES), .AW(AW)) u_array (
    .clk(clk), .wr_act(wr_act), .wr_hi(wr_hi), .wr_grp(wr_grp),
    .d_rise(d_rise), .d_fall(d_fall),
    .en_rise(~bws_rise_n), .en_fall(~bws_fall_n),
    .rd_grp(rd_grp), .rd_words(rd_words)
  );

  qb_sram_rd #(.LANES(LANES), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rps_n(rps_n), .addr(addr),
    .rd_words(rd_words), .rd_acc(rd_acc), .rd_grp(rd_grp),
    .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe)
  );
endmodule

// File: rtl/qb_sram_chk.sv
module qb_sram_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_acc,
  input logic         wr_acc,
  input logic         q_oe,
  input logic [W-1:0] q_rise,
  input logic [W-1:0] q_fall
);
  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> (q_rise == '0 && q_fall == '0));

  // R4
  read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> ##2 q_oe);

  // R4
  two_beat_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |=> q_oe);

  // R5
  no_read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);

  // R6
  no_write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);
endmodule

bind qb_sram qb_sram_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .wr_acc(wr_acc),
  .q_oe(q_oe), .q_rise(q_rise), .q_fall(q_fall)
);

// File: tb/tb_qb_sram.sv
module tb_qb_sram;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int AW = 4;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wps_n = 1'b1, rps_n = 1'b1;
  logic [LANES-1:0] bws_rise_n = '1, bws_fall_n = '1;
  logic [W-1:0] d_rise = '0, d_fall = '0;
  logic [W-1:0] q_rise, q_fall;
  logic q_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] rm [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  qb_sram #(.LANES(LANES), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wps_n(wps_n),
    .bws_rise_n(bws_rise_n), .bws_fall_n(bws_fall_n),
    .d_rise(d_rise), .d_fall(d_fall), .rps_n(rps_n),
    .q_rise(q_rise), .q_fall(q_fall), .q_oe(q_oe)
  );

  function automatic logic [W-1:0] lmix(logic [W-1:0] o, logic [W-1:0] n, logic [1:0] m_n);
    logic [W-1:0] r = o;
    if (!m_n[0]) r[8:0]  = n[8:0];
    if (!m_n[1]) r[17:9] = n[17:9];
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pair(string tag, logic [AW-1:0] g, bit hi);
    chk({tag, " oe"}, W'(q_oe), W'(1));
    chk({tag, " rise"}, q_rise, rm[{g, hi, 1'b0}]);
    chk({tag, " fall"}, q_fall, rm[{g, hi, 1'b1}]);
  endtask

  task automatic chk_idle(string tag);
    chk({tag, " oe idle"}, W'(q_oe), '0);
    chk({tag, " rise idle"}, q_rise, '0);
    chk({tag, " fall idle"}, q_fall, '0);
  endtask

  task automatic put_ref(logic [AW-1:0] g, bit hi);
    rm[{g, hi, 1'b0}] = lmix(rm[{g, hi, 1'b0}], d_rise, bws_rise_n);
    rm[{g, hi, 1'b1}] = lmix(rm[{g, hi, 1'b1}], d_fall, bws_fall_n);
  endtask

  task automatic release_wr();
    wps_n = 1'b1; bws_rise_n = '1; bws_fall_n = '1; d_rise = '0; d_fall = '0;
  endtask

  task automatic wr_burst(logic [AW-1:0] g, logic [W-1:0] w0, w1, w2, w3,
                          logic [1:0] mr0, mf0, mr1, mf1);
    wps_n = 1'b0; addr = g; d_rise = w0; d_fall = w1; bws_rise_n = mr0; bws_fall_n = mf0;
    step(); put_ref(g, 1'b0);
    wps_n = 1'b1; d_rise = w2; d_fall = w3; bws_rise_n = mr1; bws_fall_n = mf1;
    step(); put_ref(g, 1'b1);
    release_wr();
  endtask

  task automatic rd_burst(logic [AW-1:0] g, string tag);
    rps_n = 1'b0; addr = g;
    step(); rps_n = 1'b1;
    step(); chk_pair(tag, g, 1'b0);
    step(); chk_pair(tag, g, 1'b1);
    step(); chk_idle(tag);
  endtask

  // R10 R9
  task automatic t_reset();
    chk_idle("R10 reset");
    step();
    chk_idle("R9 quiet");
  endtask

  // R1 R4
  task automatic t_basic();
    wr_burst(4'd3, 18'h0A001, 18'h0B002, 18'h0C003, 18'h0D004, 2'b00, 2'b00, 2'b00, 2'b00);
    rd_burst(4'd3, "R1 R4 basic");
  endtask

  // R3
  task automatic t_mask();
    wr_burst(4'd3, 18'h3FFFF, 18'h3FFFF, 18'h15555, 18'h2AAAA, 2'b01, 2'b10, 2'b11, 2'b00);
    rd_burst(4'd3, "R3 lanes");
  endtask

  // R2
  task automatic t_deselect();
    addr = 4'd3; wps_n = 1'b1; bws_rise_n = '0; bws_fall_n = '0;
    d_rise = 18'h12345; d_fall = 18'h23456;
    step(); step();
    release_wr();
    rd_burst(4'd3, "R2 deselected");
  endtask

  // R5 R4
  task automatic t_read_pair();
    wr_burst(4'd5, 18'h05050, 18'h05151, 18'h05252, 18'h05353, 2'b00, 2'b00, 2'b00, 2'b00);
    wr_burst(4'd6, 18'h06060, 18'h06161, 18'h06262, 18'h06363, 2'b00, 2'b00, 2'b00, 2'b00);
    rps_n = 1'b0; addr = 4'd5;
    step(); addr = 4'd6;
    step(); rps_n = 1'b1; chk_pair("R5 first", 4'd5, 1'b0);
    step(); chk_pair("R5 first", 4'd5, 1'b1);
    step(); chk_idle("R5 dropped");
    step(); chk_idle("R5 dropped");
    // spaced by two cycles: continuous output
    rps_n = 1'b0; addr = 4'd3;
    step(); rps_n = 1'b1;
    step(); chk_pair("R4 chain a", 4'd3, 1'b0); rps_n = 1'b0; addr = 4'd5;
    step(); rps_n = 1'b1; chk_pair("R4 chain a", 4'd3, 1'b1);
    step(); chk_pair("R4 chain b", 4'd5, 1'b0);
    step(); chk_pair("R4 chain b", 4'd5, 1'b1);
    step(); chk_idle("R4 chain end");
  endtask

  // R6
  task automatic t_write_pair();
    wr_burst(4'd7, 18'h07070, 18'h07171, 18'h07272, 18'h07373, 2'b00, 2'b00, 2'b00, 2'b00);
    wps_n = 1'b0; addr = 4'd8; d_rise = 18'h08080; d_fall = 18'h08181; bws_rise_n = '0; bws_fall_n = '0;
    step(); put_ref(4'd8, 1'b0);
    addr = 4'd7; d_rise = 18'h08282; d_fall = 18'h08383;
    step(); put_ref(4'd8, 1'b1);
    release_wr();
    rd_burst(4'd7, "R6 untouched");
    rd_burst(4'd8, "R6 tail");
  endtask

  // R7 same edge
  task automatic t_fwd_same();
    wr_burst(4'd9, 18'h09000, 18'h09001, 18'h09002, 18'h09003, 2'b00, 2'b00, 2'b00, 2'b00);
    rps_n = 1'b0; wps_n = 1'b0; addr = 4'd9;
    d_rise = 18'h19A10; d_fall = 18'h19A11; bws_rise_n = '0; bws_fall_n = '0;
    step(); put_ref(4'd9, 1'b0);
    rps_n = 1'b1; wps_n = 1'b1;
    d_rise = 18'h29A12; d_fall = 18'h29A13; bws_rise_n = 2'b10; bws_fall_n = 2'b00;
    step(); put_ref(4'd9, 1'b1);
    release_wr();
    chk_pair("R7 same", 4'd9, 1'b0);
    step(); chk_pair("R7 same", 4'd9, 1'b1);
    step(); chk_idle("R7 same");
  endtask

  // R7 previous edge
  task automatic t_fwd_prev();
    wps_n = 1'b0; addr = 4'd10; d_rise = 18'h0AA00; d_fall = 18'h0AA01;
    bws_rise_n = '0; bws_fall_n = '0;
    step(); put_ref(4'd10, 1'b0);
    wps_n = 1'b1; rps_n = 1'b0; d_rise = 18'h0AA02; d_fall = 18'h0AA03;
    step(); put_ref(4'd10, 1'b1);
    rps_n = 1'b1; release_wr();
    step(); chk_pair("R7 prev", 4'd10, 1'b0);
    step(); chk_pair("R7 prev", 4'd10, 1'b1);
    step(); chk_idle("R7 prev");
  endtask

  // R8
  task automatic t_write_after_read();
    wr_burst(4'd11, 18'h0B100, 18'h0B101, 18'h0B102, 18'h0B103, 2'b00, 2'b00, 2'b00, 2'b00);
    rps_n = 1'b0; addr = 4'd11;
    step(); rps_n = 1'b1;
    wps_n = 1'b0; d_rise = 18'h3B200; d_fall = 18'h3B201; bws_rise_n = '0; bws_fall_n = '0;
    step(); chk_pair("R8 old", 4'd11, 1'b0); put_ref(4'd11, 1'b0);
    wps_n = 1'b1; d_rise = 18'h3B202; d_fall = 18'h3B203;
    step(); chk_pair("R8 old", 4'd11, 1'b1); put_ref(4'd11, 1'b1);
    release_wr();
    step(); chk_idle("R8 end");
    rd_burst(4'd11, "R8 new");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_deselect();
    t_read_pair();
    t_write_pair();
    t_fwd_same();
    t_fwd_prev();
    t_write_after_read();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule